// File: doc/BRIEF.md
# Subblock Data Pool Allocator

This block hands out storage for cache lines from a shared pool of small, fixed-size data subblocks. A line is not tied to one fixed data slot. When a line is filled, the allocator grants a full line's worth of subblocks at once and returns their indices, which the tag logic stores as the line's data pointers. Every subblock carries a saturating reference count, so one subblock can be shared by several lines. It goes back into the pool only when the last reference to it is dropped.

If the pool holds fewer free subblocks than one line needs, the block does not grant the fill. It raises an eviction request and keeps raising it for as long as the fill request stays up. Once frees have brought the count back up to a line's worth, the fill is granted. The block also holds the chained free list of secondary tag entries, the entries that come after the primary tag table. Entries are taken from the head of this list and returned to the head.

Top module: `subblock_pool`

## Requirements
- R1: After reset every subblock is free with a count of zero, `free_count` equals POOL_BYTES/SUB_BYTES, `fill_gnt` and `evict_req` are low, and the tag list head is PRIMARY_TAGS with `tag_avail` high.
- R2: While `fill_req` is high and `free_count` is at least LINE_BYTES/SUB_BYTES, `fill_gnt` is high in the same cycle. `fill_ptrs` then carries the lowest-indexed free subblocks in ascending order, with slot 0 in bits [IW-1:0] and slot s in bits [s*IW +: IW].
- R3: A granted fill lowers `free_count` by one line's worth of subblocks on the next cycle, and each subblock it took gets a count of one.
- R4: While `fill_req` is high and too few subblocks are free, `evict_req` is high, `fill_gnt` is low and no subblock is taken. The fill is granted in the first cycle that enough subblocks are free.
- R5: `ref_req` adds one to the count of subblock `ref_idx` when that count is non-zero, so one more free is needed before the subblock is released. On a subblock that is already free, it has no effect.
- R6: `free_req` subtracts one from the count of each subblock named in the slots of `free_ptrs`. A subblock whose count reaches zero adds to `free_count` on the next cycle. Slots that name an already free subblock are ignored.
- R7: A subblock freed in a given cycle cannot be used by a fill request in that same cycle.
- R8: Tag entries are handed out from the list head. After reset, successive pops give PRIMARY_TAGS up to PRIMARY_TAGS+SECONDARY_TAGS-1. After that `tag_avail` goes low and `tag_head` holds the null value PRIMARY_TAGS+SECONDARY_TAGS.
- R9: `tag_push` makes `tag_push_idx` the new list head, so the list is last-in first-out. A pushed index outside the secondary range is ignored.
- R10: A pop on an empty list is ignored. A pop and a push in the same cycle remove the old head and leave the pushed entry as head, linked to the entry that followed the old head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_req | input | 1 | Request subblocks for one whole line |
| fill_gnt | output | 1 | Fill accepted this cycle |
| evict_req | output | 1 | Fill waiting: too few free subblocks, a victim must be evicted |
| fill_ptrs | output | SUBS*IW | Indices of the granted subblocks, slot 0 lowest |
| ref_req | input | 1 | Add a reference to one subblock |
| ref_idx | input | IW | Subblock that gets the added reference |
| free_req | input | 1 | Drop one reference from each slot of `free_ptrs` |
| free_ptrs | input | SUBS*IW | Data pointers of the line being released |
| free_count | output | CW | Number of subblocks now free |
| tag_pop | input | 1 | Take the head of the tag free list |
| tag_push | input | 1 | Return a tag entry to the list |
| tag_push_idx | input | TW | Tag entry being returned |
| tag_avail | output | 1 | Tag free list is not empty |
| tag_head | output | TW | Current head of the tag free list |

## Verification
The bench uses the default parameters: a 256-byte pool, 32-byte lines and 8-byte subblocks, which gives 32 subblocks at four per line, plus eight primary and eight secondary tags. With eight fills the pool can be driven empty. This puts the stalled fill, a free and a fill in the same cycle, and a shared subblock that survives one free all within a few dozen cycles. With eight secondary tags the list can be emptied and refilled, so popping on an empty list, pushing an index out of range and popping and pushing in the same cycle can each be tried.

// File: rtl/subblock_pool.sv
module subblock_pool #(
  parameter int POOL_BYTES     = 256,
  parameter int LINE_BYTES     = 32,
  parameter int SUB_BYTES      = 8,
  parameter int PRIMARY_TAGS   = 8,
  parameter int SECONDARY_TAGS = 8,
  parameter int REF_W          = 3,
  localparam int SUBS       = LINE_BYTES / SUB_BYTES,
  localparam int ENTRIES    = POOL_BYTES / SUB_BYTES,
  localparam int IW         = $clog2(ENTRIES),
  localparam int CW         = $clog2(ENTRIES + 1),
  localparam int TOTAL_TAGS = PRIMARY_TAGS + SECONDARY_TAGS,
  localparam int TW         = $clog2(TOTAL_TAGS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_req,
  output logic               fill_gnt,
  output logic               evict_req,
  output logic [SUBS*IW-1:0] fill_ptrs,
  input  logic               ref_req,
  input  logic [IW-1:0]      ref_idx,
  input  logic               free_req,
  input  logic [SUBS*IW-1:0] free_ptrs,
  output logic [CW-1:0]      free_count,
  input  logic               tag_pop,
  input  logic               tag_push,
  input  logic [TW-1:0]      tag_push_idx,
  output logic               tag_avail,
  output logic [TW-1:0]      tag_head
);

  localparam int SLOTS  = 1 << IW;
  localparam int TSLOTS = 1 << TW;
  localparam logic [TW-1:0]    TNULL = TW'(TOTAL_TAGS);
  localparam logic [REF_W-1:0] RMAX  = '1;

  logic [REF_W-1:0] refc [SLOTS];
  logic [REF_W-1:0] refn [SLOTS];
  logic [IW-1:0]    pick [SUBS];
  logic [SLOTS-1:0] taken;
  logic [CW-1:0]    nfree, nfree_n;
  logic             enough;

  assign enough     = nfree >= CW'(SUBS);
  assign fill_gnt   = fill_req && enough;
  assign evict_req  = fill_req && !enough;
  assign free_count = nfree;

  always_comb begin : pick_lowest
    int k;
    k = 0;
    taken = '0;
    for (int s = 0; s < SUBS; s++) pick[s] = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (refc[e] == '0 && k < SUBS) begin
        pick[k]  = IW'(e);
        taken[e] = fill_gnt;
        k++;
      end
    end
  end

  for (genvar s = 0; s < SUBS; s++) begin : g_ptr
    assign fill_ptrs[s*IW +: IW] = pick[s];
  end

  always_comb begin : next_counts
    int dec;
    logic [REF_W:0] sum;
    nfree_n = nfree - (fill_gnt ? CW'(SUBS) : '0);
    for (int e = 0; e < SLOTS; e++) begin
      dec = 0;
      for (int s = 0; s < SUBS; s++)
        if (free_req && free_ptrs[s*IW +: IW] == IW'(e)) dec++;
      sum = {1'b0, refc[e]} +
            ((ref_req && ref_idx == IW'(e) && refc[e] != '0 && refc[e] != RMAX)
              ? (REF_W+1)'(1) : '0);
      if (taken[e])           refn[e] = REF_W'(1);
      else if (int'(sum) <= dec) refn[e] = '0;
      else                    refn[e] = REF_W'(int'(sum) - dec);
      if (refc[e] != '0 && refn[e] == '0) nfree_n = nfree_n + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < SLOTS; e++) refc[e] <= '0;
      nfree <= CW'(ENTRIES);
    end else begin
      for (int e = 0; e < SLOTS; e++) refc[e] <= refn[e];
      nfree <= nfree_n;
    end
  end

  logic [TW-1:0] head;
  logic [TW-1:0] link [TSLOTS];
  logic          pop_ok, push_ok;

  assign tag_avail = head != TNULL;
  assign tag_head  = head;
  assign pop_ok    = tag_pop && tag_avail;
  assign push_ok   = tag_push && tag_push_idx >= TW'(PRIMARY_TAGS) && tag_push_idx < TNULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= TW'(PRIMARY_TAGS);
      for (int t = 0; t < TSLOTS; t++) link[t] <= TW'(t + 1);
    end else if (push_ok) begin
      link[tag_push_idx] <= pop_ok ? link[head] : head;
      head <= tag_push_idx;
    end else if (pop_ok) begin
      head       <= link[head];
      link[head] <= TNULL;
    end
  end

endmodule

// File: rtl/subblock_pool_chk.sv
module subblock_pool_chk #(
  parameter int POOL_BYTES     = 256,
  parameter int LINE_BYTES     = 32,
  parameter int SUB_BYTES      = 8,
  parameter int PRIMARY_TAGS   = 8,
  parameter int SECONDARY_TAGS = 8,
  localparam int SUBS    = LINE_BYTES / SUB_BYTES,
  localparam int ENTRIES = POOL_BYTES / SUB_BYTES,
  localparam int IW      = $clog2(ENTRIES),
  localparam int CW      = $clog2(ENTRIES + 1),
  localparam int TOTAL   = PRIMARY_TAGS + SECONDARY_TAGS,
  localparam int TW      = $clog2(TOTAL + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fill_req,
  input logic               fill_gnt,
  input logic               evict_req,
  input logic [SUBS*IW-1:0] fill_ptrs,
  input logic               ref_req,
  input logic               free_req,
  input logic [CW-1:0]      free_count,
  input logic               tag_pop,
  input logic               tag_push,
  input logic               tag_avail,
  input logic [TW-1:0]      tag_head
);

  assert_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    free_count <= CW'(ENTRIES));

  assert_grant_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_gnt |-> free_count >= CW'(SUBS));

  assert_fill_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_gnt && !free_req && !ref_req) |=> free_count == $past(free_count) - CW'(SUBS));

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evict_req |-> (!fill_gnt && fill_req && free_count < CW'(SUBS)));

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_avail && tag_pop && !tag_push) |=> !tag_avail);

  assert_head_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_avail |-> (tag_head >= TW'(PRIMARY_TAGS) && tag_head < TW'(TOTAL)));

  always @(posedge clk) begin
    if (rst_n && fill_gnt)
      for (int s = 1; s < SUBS; s++)
        assert_ascending_R2: assert (fill_ptrs[s*IW +: IW] > fill_ptrs[(s-1)*IW +: IW]);
  end

endmodule

bind subblock_pool subblock_pool_chk #(
  .POOL_BYTES(POOL_BYTES), .LINE_BYTES(LINE_BYTES), .SUB_BYTES(SUB_BYTES),
  .PRIMARY_TAGS(PRIMARY_TAGS), .SECONDARY_TAGS(SECONDARY_TAGS)
) u_chk (.*);

// File: tb/tb_subblock_pool.sv
module tb_subblock_pool;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_req = 0, ref_req = 0, free_req = 0, tag_pop = 0, tag_push = 0;
  logic        fill_gnt, evict_req, tag_avail;
  logic [19:0] fill_ptrs;
  logic [19:0] free_ptrs = '0;
  logic [4:0]  ref_idx = '0, tag_push_idx = '0, tag_head;
  logic [5:0]  free_count;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  subblock_pool dut (.*);

  task automatic check(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [19:0] pk(int a, int b, int c, int d);
    return {5'(d), 5'(c), 5'(b), 5'(a)};
  endfunction

  // {pop, push, idx, expected avail, expected head}
  localparam logic [12:0] TV [16] = '{
    {1'b1, 1'b0, 5'd0,  1'b1, 5'd9},
    {1'b1, 1'b0, 5'd0,  1'b1, 5'd10},
    {1'b0, 1'b1, 5'd8,  1'b1, 5'd8},
    {1'b1, 1'b0, 5'd0,  1'b1, 5'd10},
    {1'b0, 1'b1, 5'd3,  1'b1, 5'd10},
    {1'b1, 1'b1, 5'd9,  1'b1, 5'd9},
    {1'b1, 1'b0, 5'd0,  1'b1, 5'd11},
    {1'b1, 1'b0, 5'd0,  1'b1, 5'd12},
    {1'b1, 1'b0, 5'd0,  1'b1, 5'd13},
    {1'b1, 1'b0, 5'd0,  1'b1, 5'd14},
    {1'b1, 1'b0, 5'd0,  1'b1, 5'd15},
    {1'b1, 1'b0, 5'd0,  1'b0, 5'd16},
    {1'b1, 1'b0, 5'd0,  1'b0, 5'd16},
    {1'b0, 1'b1, 5'd12, 1'b1, 5'd12},
    {1'b1, 1'b0, 5'd0,  1'b0, 5'd16},
    {1'b0, 1'b1, 5'd16, 1'b0, 5'd16}
  };

  task automatic do_fill(string tag, logic [19:0] exp_ptrs, int exp_after);
    @(negedge clk); fill_req = 1;
    #1;
    check({tag, " fill_gnt"}, fill_gnt, 1);
    check({tag, " fill_ptrs"}, fill_ptrs, exp_ptrs);
    @(negedge clk); fill_req = 0;
    check("R3 free_count after fill", free_count, exp_after);
  endtask

  task automatic do_free(logic [19:0] ptrs, int exp_after, string tag);
    @(negedge clk); free_req = 1; free_ptrs = ptrs;
    @(negedge clk); free_req = 0;
    check({tag, " free_count after free"}, free_count, exp_after);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 free_count", free_count, 32);
    check("R1 fill_gnt", fill_gnt, 0);
    check("R1 evict_req", evict_req, 0);
    check("R1 tag_avail", tag_avail, 1);
    check("R1 tag_head", tag_head, 8);

    // tag free list walk (R8 R9 R10)
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      tag_pop = TV[i][12]; tag_push = TV[i][11]; tag_push_idx = TV[i][10:6];
      @(negedge clk);
      tag_pop = 0; tag_push = 0;
      check($sformatf("R8 R9 R10 step %0d tag_avail", i), tag_avail, TV[i][5]);
      check($sformatf("R8 R9 R10 step %0d tag_head", i), tag_head, TV[i][4:0]);
    end

    // pool fills (R2 R3)
    do_fill("R2", pk(0, 1, 2, 3), 28);
    do_fill("R2", pk(4, 5, 6, 7), 24);

    // R5: share subblock 1, reference to free subblock 20 ignored
    @(negedge clk); ref_req = 1; ref_idx = 5'd1;
    @(negedge clk); ref_idx = 5'd20;
    @(negedge clk); ref_req = 0;
    check("R5 free_count after refs", free_count, 24);

    do_fill("R2", pk(8, 9, 10, 11), 20);
    do_fill("R2", pk(12, 13, 14, 15), 16);
    do_fill("R2", pk(16, 17, 18, 19), 12);
    do_fill("R5 R2", pk(20, 21, 22, 23), 8);
    do_fill("R2", pk(24, 25, 26, 27), 4);
    do_fill("R2", pk(28, 29, 30, 31), 0);

    // R4: empty pool stalls
    @(negedge clk); fill_req = 1;
    #1;
    check("R4 evict_req when empty", evict_req, 1);
    check("R4 fill_gnt when empty", fill_gnt, 0);
    @(negedge clk);
    check("R4 free_count unchanged", free_count, 0);

    // R7: free in same cycle as waiting fill
    free_req = 1; free_ptrs = pk(0, 1, 2, 3);
    #1;
    check("R7 fill_gnt same cycle as free", fill_gnt, 0);
    check("R7 evict_req same cycle as free", evict_req, 1);
    @(negedge clk); free_req = 0;
    check("R6 R5 shared subblock kept", free_count, 3);
    #1;
    check("R4 evict_req still short", evict_req, 1);
    @(negedge clk); fill_req = 0;

    do_free(pk(1, 20, 21, 22), 7, "R6");
    do_fill("R4", pk(0, 1, 2, 3), 3);
    do_free(pk(20, 20, 20, 20), 3, "R6 ignored");
    check("R6 fill_gnt idle", fill_gnt, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule